// File: doc/BRIEF.md
# ADC Result Capture with Compare Gating

This block sits after a successive-approximation converter and captures each finished conversion into a result register. Software reads that register through two byte-wide ports. The high byte carries only the top two result bits, and the low byte carries the rest. A width select chooses between narrow (8-bit) and wide (10-bit) results.

An optional automatic compare decides whether a finished conversion is stored. The compare can trigger when the result is below a programmed level, or when it is at or above that level. A result that fails the compare is dropped, and the register keeps its previous value.

In wide mode, reading the high byte locks the register so that the two bytes of one sample stay together. Conversions that finish while the lock is held are discarded. Reading the low byte releases the lock.

Changing the width select invalidates whatever the register holds. The register is cleared at that point.

Top module: `adc_res_capture`

## Requirements
- R1: The high byte carries result bits 9..8 in its bit positions 1..0, and its bits 7..2 always read 0. Both bytes read 0 after reset.
- R2: With `mode_wide_i`=0 (narrow mode), a stored result has a high byte of 0 and a low byte equal to `conv_data_i[7:0]`. Bits 9..8 of `conv_data_i` are ignored.
- R3: With `mode_wide_i`=1 (wide mode), a stored result has a low byte equal to `conv_data_i[7:0]` and high-byte bits 1..0 equal to `conv_data_i[9:8]`.
- R4: With `cmp_en_i`=0, every `conv_done_i` pulse that is not blocked by the lock updates the outputs on the clock edge that samples the pulse. Without a pulse, the outputs hold.
- R5: With `cmp_en_i`=1, a finished conversion is stored only when the compare condition holds. Otherwise both bytes keep their previous values.
- R6: With `cmp_ge_i`=0 the condition is result < level, and with `cmp_ge_i`=1 it is result >= level. In wide mode all 10 bits of data and `cmp_level_i` are compared. In narrow mode only bits 7..0 of each are compared.
- R7: In wide mode, a `rd_hi_i` strobe sets a lock. While the lock is set, finished conversions are discarded. A `rd_lo_i` strobe clears the lock.
- R8: When `rd_lo_i` and `conv_done_i` occur in the same cycle, the new conversion is stored, subject to the compare. The read sees the old value.
- R9: In narrow mode a `rd_hi_i` strobe never sets the lock, so reads never block updates.
- R10: A change of `mode_wide_i` clears both bytes and the lock on the next edge. A conversion finishing in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle conversion-complete strobe |
| conv_data_i | input | 10 | Conversion result |
| mode_wide_i | input | 1 | 1 selects 10-bit results, 0 selects 8-bit |
| cmp_en_i | input | 1 | Enables compare gating |
| cmp_ge_i | input | 1 | Compare polarity: 1 means >=, 0 means < |
| cmp_level_i | input | 10 | Compare level |
| rd_hi_i | input | 1 | One-cycle strobe: high byte is being read |
| rd_lo_i | input | 1 | One-cycle strobe: low byte is being read |
| res_hi_o | output | 8 | High result byte |
| res_lo_o | output | 8 | Low result byte |

## Verification
Every 10-bit code is converted with compare off in wide mode, and every code is also converted in narrow mode with junk in bits 9..8. Together these separate a correct byte split from a wrong bit slice or a leak of the upper bits in narrow mode.

Each compare polarity is then swept over all codes against several levels, including 0 and full scale. This catches off-by-one boundary errors and swapped polarities. A narrow-mode sweep uses a level with its upper bits set, which exposes any compare that uses all 10 bits in narrow mode.

Directed sequences lock the register and issue conversions behind the lock. They then combine a low-byte read with a conversion in the same cycle, and switch modes while the lock is held. These sequences distinguish a discarded sample from a delayed one.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  parameter int unsigned RES_W    = 10;
  parameter int unsigned NARROW_W = 8;
  parameter int unsigned BYTE_W   = 8;

  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_GE = 1'b1
  } cmp_pol_e;
endpackage

// File: rtl/adc_res_cmp.sv
module adc_res_cmp #(
  parameter int unsigned RES_W    = adc_res_pkg::RES_W,
  parameter int unsigned NARROW_W = adc_res_pkg::NARROW_W
) (
  input  logic             wide_i,
  input  logic             en_i,
  input  logic             ge_i,
  input  logic [RES_W-1:0] data_i,
  input  logic [RES_W-1:0] level_i,
  output logic             pass_o
);
  import adc_res_pkg::*;

  logic [RES_W-1:0] data_m, level_m;
  logic             ge_true;

  // narrow mode compares only the low NARROW_W bits
  generate
    if (NARROW_W < RES_W) begin : g_mask
      always_comb begin
        data_m  = data_i;
        level_m = level_i;
        if (!wide_i) begin
          data_m[RES_W-1:NARROW_W]  = '0;
          level_m[RES_W-1:NARROW_W] = '0;
        end
      end
    end else begin : g_nomask
      assign data_m  = data_i;
      assign level_m = level_i;
    end
  endgenerate

  assign ge_true = (data_m >= level_m);

  always_comb begin
    if (!en_i)                       pass_o = 1'b1;
    else if (cmp_pol_e'(ge_i) == CMP_GE) pass_o = ge_true;
    else                             pass_o = ~ge_true;
  end
endmodule

// File: rtl/adc_res_lock.sv
module adc_res_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wide_i,
  input  logic rd_hi_i,
  input  logic rd_lo_i,
  output logic mode_chg_o,
  output logic lock_o,
  output logic xfer_ok_o
);
  logic mode_q;

  assign mode_chg_o = (mode_wide_i != mode_q);
  // low-byte read in the same cycle releases the lock for this conversion
  assign xfer_ok_o  = ~mode_chg_o & (~lock_o | rd_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      mode_q <= mode_wide_i;
      if (mode_chg_o)                lock_o <= 1'b0;
      else if (rd_hi_i && mode_wide_i) lock_o <= 1'b1;
      else if (rd_lo_i)              lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int unsigned RES_W    = adc_res_pkg::RES_W,
  parameter int unsigned NARROW_W = adc_res_pkg::NARROW_W,
  parameter int unsigned BYTE_W   = adc_res_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [RES_W-1:0]  data_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int unsigned HI_W  = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W;

  logic [RES_W-1:0] res_q, load_val;

  always_comb begin
    load_val = data_i;
    if (!wide_i) load_val[RES_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (clr_i)  res_q <= '0;
    else if (load_i) res_q <= load_val;
  end

  assign hi_o = {{PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};
  assign lo_o = res_q[BYTE_W-1:0];
endmodule

// File: rtl/adc_res_capture.sv
module adc_res_capture #(
  parameter int unsigned RES_W    = adc_res_pkg::RES_W,
  parameter int unsigned NARROW_W = adc_res_pkg::NARROW_W,
  parameter int unsigned BYTE_W   = adc_res_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              mode_wide_i,
  input  logic              cmp_en_i,
  input  logic              cmp_ge_i,
  input  logic [RES_W-1:0]  cmp_level_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic [BYTE_W-1:0] res_lo_o
);
  logic cmp_pass, mode_chg, lock_q, xfer_ok, store_en;

  adc_res_cmp #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_cmp (
    .wide_i  (mode_wide_i),
    .en_i    (cmp_en_i),
    .ge_i    (cmp_ge_i),
    .data_i  (conv_data_i),
    .level_i (cmp_level_i),
    .pass_o  (cmp_pass)
  );

  adc_res_lock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_wide_i (mode_wide_i),
    .rd_hi_i     (rd_hi_i),
    .rd_lo_i     (rd_lo_i),
    .mode_chg_o  (mode_chg),
    .lock_o      (lock_q),
    .xfer_ok_o   (xfer_ok)
  );

  assign store_en = conv_done_i & cmp_pass & xfer_ok;

  adc_res_store #(.RES_W(RES_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_chg),
    .load_i (store_en),
    .wide_i (mode_wide_i),
    .data_i (conv_data_i),
    .hi_o   (res_hi_o),
    .lo_o   (res_lo_o)
  );
endmodule

// File: rtl/adc_res_capture_chk.sv
module adc_res_capture_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_done_i,
  input logic [RES_W-1:0]  conv_data_i,
  input logic              mode_wide_i,
  input logic              cmp_en_i,
  input logic              cmp_ge_i,
  input logic [RES_W-1:0]  cmp_level_i,
  input logic              rd_lo_i,
  input logic [BYTE_W-1:0] res_hi_o,
  input logic [BYTE_W-1:0] res_lo_o,
  input logic              lock_q,
  input logic              mode_chg
);
  localparam int unsigned HI_W = RES_W - BYTE_W;

  // R2
  narrow_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wide_i && !mode_chg |=> res_hi_o == '0);

  // R4
  cmp_off_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !cmp_en_i && !lock_q && !mode_chg |=> res_lo_o == $past(conv_data_i[BYTE_W-1:0]));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i && !mode_chg |=> $stable(res_hi_o) && $stable(res_lo_o));

  // R6
  ge_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && cmp_en_i && cmp_ge_i && mode_wide_i && !mode_chg && !lock_q &&
    (conv_data_i >= cmp_level_i)
    |=> {res_hi_o[HI_W-1:0], res_lo_o} == $past(conv_data_i));

  // R5
  lt_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && !cmp_ge_i && mode_wide_i && !mode_chg && (conv_data_i >= cmp_level_i)
    |=> $stable(res_hi_o) && $stable(res_lo_o));

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !rd_lo_i && !mode_chg |=> $stable(res_hi_o) && $stable(res_lo_o));

  // R9
  narrow_no_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wide_i |=> !lock_q);

  // R10
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> res_hi_o == '0 && res_lo_o == '0 && !lock_q);
endmodule

bind adc_res_capture adc_res_capture_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .conv_data_i (conv_data_i),
  .mode_wide_i (mode_wide_i),
  .cmp_en_i    (cmp_en_i),
  .cmp_ge_i    (cmp_ge_i),
  .cmp_level_i (cmp_level_i),
  .rd_lo_i     (rd_lo_i),
  .res_hi_o    (res_hi_o),
  .res_lo_o    (res_lo_o),
  .lock_q      (lock_q),
  .mode_chg    (mode_chg)
);

// File: tb/adc_res_capture_bench.sv
`timescale 1ns/1ps
module adc_res_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [9:0] data = '0;
  logic       wide = 1'b0;
  logic       cen = 1'b0;
  logic       cge = 1'b0;
  logic [9:0] lvl = '0;
  logic       rh = 1'b0;
  logic       rl = 1'b0;
  logic [7:0] hi, lo;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  // reference model state
  logic [9:0] m_res  = '0;
  logic       m_lock = 1'b0;
  logic       m_mode = 1'b0;

  always #10 clk = ~clk;

  adc_res_capture u_adc_res_capture (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(done), .conv_data_i(data),
    .mode_wide_i(wide), .cmp_en_i(cen), .cmp_ge_i(cge), .cmp_level_i(lvl),
    .rd_hi_i(rh), .rd_lo_i(rl), .res_hi_o(hi), .res_lo_o(lo)
  );

  task automatic check(input string req);
    logic [7:0] e_hi, e_lo;
    e_hi = {6'b0, m_res[9:8]};
    e_lo = m_res[7:0];
    checks++;
    if (hi !== e_hi || lo !== e_lo) begin
      fails++;
      $display("FAIL %s hi=%h lo=%h expected hi=%h lo=%h", req, hi, lo, e_hi, e_lo);
    end
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(input logic d_done, input logic [9:0] d, input logic d_rh,
                      input logic d_rl, input logic d_wide, input string req);
    logic [9:0] dm, lm;
    logic       pass;
    @(negedge clk);
    done = d_done; data = d; rh = d_rh; rl = d_rl; wide = d_wide;
    if (d_wide != m_mode) begin
      m_res = '0; m_lock = 1'b0;
    end else begin
      dm = d_wide ? d : {2'b0, d[7:0]};
      lm = d_wide ? lvl : {2'b0, lvl[7:0]};
      pass = !cen || (cge ? (dm >= lm) : (dm < lm));
      if (d_done && pass && (!m_lock || d_rl)) m_res = dm;
      if (d_rh && d_wide) m_lock = 1'b1;
      else if (d_rl)      m_lock = 1'b0;
    end
    m_mode = d_wide;
    @(posedge clk);
    #2;
    check(req);
    done = 1'b0; rh = 1'b0; rl = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    // R2 R4: narrow sweep, junk in bits 9..8
    for (int d = 0; d < 256; d++)
      step(1'b1, 10'(d) | 10'((d % 4) << 8), 1'b0, 1'b0, 1'b0, "R2/R4 narrow sweep");
    step(1'b0, 10'h3ff, 1'b0, 1'b0, 1'b0, "R4 idle hold");

    // R9: high read in narrow mode does not block
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 narrow hi read");
    step(1'b1, 10'h05a, 1'b0, 1'b0, 1'b0, "R9 narrow update after hi read");

    // R10: mode switch clears, conversion in that cycle dropped
    step(1'b1, 10'h2c3, 1'b0, 1'b0, 1'b1, "R10 mode change clears");

    // R1 R3 R4: wide sweep
    for (int d = 0; d < 1024; d++)
      step(1'b1, 10'(d), 1'b0, 1'b0, 1'b1, "R1/R3/R4 wide sweep");

    // R5 R6: compare sweeps in wide mode
    cen = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int li = 0; li < 4; li++) begin
        cge = p[0];
        lvl = (li == 0) ? 10'h000 : (li == 1) ? 10'h001 : (li == 2) ? 10'h155 : 10'h3ff;
        for (int d = 0; d < 1024; d++)
          step(1'b1, 10'(d), 1'b0, 1'b0, 1'b1, "R5/R6 wide compare");
      end
    end

    // R6: narrow compare ignores upper level bits
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 to narrow");
    lvl = 10'h2a5;
    for (int p = 0; p < 2; p++) begin
      cge = p[0];
      for (int d = 0; d < 1024; d++)
        step(1'b1, 10'(d), 1'b0, 1'b0, 1'b0, "R6 narrow compare");
    end
    cen = 1'b0;

    // R7 R8: interlock in wide mode
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R10 to wide");
    step(1'b1, 10'h1a7, 1'b0, 1'b0, 1'b1, "R7 first sample");
    step(1'b0, '0, 1'b1, 1'b0, 1'b1, "R7 hi read locks");
    step(1'b1, 10'h2b8, 1'b0, 1'b0, 1'b1, "R7 blocked sample dropped");
    step(1'b1, 10'h3c9, 1'b0, 1'b0, 1'b1, "R7 blocked sample dropped");
    step(1'b1, 10'h0da, 1'b0, 1'b1, 1'b1, "R8 lo read with conversion");
    step(1'b1, 10'h1eb, 1'b0, 1'b0, 1'b1, "R7 unlocked update");
    step(1'b0, '0, 1'b1, 1'b0, 1'b1, "R7 hi read locks");
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, "R7 lo read unlocks");
    step(1'b1, 10'h2fc, 1'b0, 1'b0, 1'b1, "R7 update after unlock");

    // R10: mode change while locked releases lock
    step(1'b0, '0, 1'b1, 1'b0, 1'b1, "R7 hi read locks");
    step(1'b1, 10'h111, 1'b0, 1'b0, 1'b0, "R10 change while locked");
    step(1'b1, 10'h333, 1'b0, 1'b0, 1'b0, "R10 lock released");

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule